// File: doc/BRIEF.md
# Frame Reader Descriptor Control

This block is the command front end of a frame reader that fetches video frames from external memory. Software writes a frame's start address into one register and its width and height into another. The geometry write commits the pair as one descriptor. A capability register shows a Ready flag, which tells software when the next descriptor can be committed. The same register reports the largest width and height the reader supports, both fixed at elaboration.

Once enabled, the block hands descriptors to the read engine over a valid/ready handshake. The engine pulses a done input when it has read a whole frame. That pulse raises a sticky interrupt, which software clears by writing one to it. If no new descriptor is waiting when a frame ends, the block issues the previous descriptor again, marked as a repeat. Two counters, one for fresh frames and one for repeats, advance when the engine accepts a descriptor. Clearing the run bit stops new issues, but a frame already handed over is allowed to finish.

Top module: `frame_rd_ctrl`

## Requirements
- R1: After reset the run bit (word 0 bit 0), the interrupt (word 2 bit 0), both counters (words 3 and 4), the busy flag and `desc_valid_o` all read 0, and the Ready flag reads 1.
- R2: Word 7 reads the Ready flag at bit 26, the width limit MAX_W at bits 25:13 and the height limit MAX_H at bits 12:0.
- R3: A write to word 5 (width at bits 25:13, height at bits 12:0) commits a descriptor made of that geometry and the start address in word 6. The Ready flag is 0 from the next cycle until that descriptor has been presented and accepted by the engine.
- R4: When run is 1 and no descriptor is presented or in flight, a waiting descriptor appears on `desc_valid_o` at the next clock edge. Valid and its payload stay stable until `desc_ready_i` is sampled high.
- R5: A committed width above MAX_W or height above MAX_H is replaced by the limit, both in word 5 read-back and on the descriptor ports.
- R6: `frame_done_i` while a frame is in flight sets word 2 bit 0 and `irq_o` at the next edge. Writing 1 to word 2 bit 0 clears it, and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R7: When a frame ends with run at 1 and no new descriptor waiting, the previous descriptor is presented again with `desc_repeat_o` at 1. Word 4 increments when the engine accepts a repeat.
- R8: Word 3 increments when the engine accepts a fresh (non-repeat) descriptor.
- R9: With run at 0 no descriptor is launched. A descriptor already presented stays valid until it is accepted, and a frame in flight still completes and raises the interrupt.
- R10: Word 1 bit 0 is 1 while a descriptor is presented or a frame is in flight, and 0 otherwise.
- R11: `frame_done_i` while no frame is in flight has no effect on the interrupt or on the counters.
- R12: Word 6 reads back the last value written to it. Writes to word 6 after a commit do not change a descriptor that was already committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Frame-complete interrupt |
| desc_valid_o | output | 1 | Descriptor presented to the read engine |
| desc_ready_i | input | 1 | Read engine accepts the descriptor |
| desc_addr_o | output | ADDR_W | Frame start address |
| desc_width_o | output | 13 | Frame width, clamped |
| desc_height_o | output | 13 | Frame height, clamped |
| desc_repeat_o | output | 1 | Descriptor repeats the previous frame |
| frame_done_i | input | 1 | Read engine has finished a whole frame |

## Verification
The bench builds the block with MAX_W of 640 and MAX_H of 480. With these small limits, 13-bit geometry writes such as 1000 by 900 lie beyond both limits, so clamping is seen both in read-back and on the descriptor ports. CNT_W is 8, which keeps the counters short while they are still read through full 32-bit words. The directed part runs the block through fresh issue, repeat, interrupt clear, a stray done pulse, and a stop with a descriptor still presented.

// File: rtl/frm_rd_pkg.sv
`timescale 1ns/1ps
package frm_rd_pkg;
  localparam int unsigned DIM_W   = 13;
  localparam int unsigned W_LSB   = 13;
  localparam int unsigned RDY_BIT = 26;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_STAT  = 4'd1;
  localparam logic [3:0] A_IRQ   = 4'd2;
  localparam logic [3:0] A_FRESH = 4'd3;
  localparam logic [3:0] A_RPT   = 4'd4;
  localparam logic [3:0] A_GEOM  = 4'd5;
  localparam logic [3:0] A_BASE  = 4'd6;
  localparam logic [3:0] A_CAPS  = 4'd7;

  typedef struct packed {
    logic [DIM_W-1:0] w;
    logic [DIM_W-1:0] h;
  } geom_t;
endpackage

// File: rtl/frm_rd_clamp.sv
`timescale 1ns/1ps
module frm_rd_clamp
  import frm_rd_pkg::*;
#(
  parameter int unsigned MAX_W = 1920,
  parameter int unsigned MAX_H = 1080
) (
  input  geom_t raw_i,
  output geom_t clp_o
);
  localparam logic [DIM_W-1:0] LIM_W = DIM_W'(MAX_W);
  localparam logic [DIM_W-1:0] LIM_H = DIM_W'(MAX_H);

  always_comb begin
    clp_o.w = (raw_i.w > LIM_W) ? LIM_W : raw_i.w;
    clp_o.h = (raw_i.h > LIM_H) ? LIM_H : raw_i.h;
  end
endmodule

// File: rtl/frm_rd_cnt.sv
`timescale 1ns/1ps
module frm_rd_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  // R7 R8
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == W'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/frm_rd_regs.sv
`timescale 1ns/1ps
module frm_rd_regs
  import frm_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MAX_W  = 1920,
  parameter int unsigned MAX_H  = 1080,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              frame_end_i,
  input  logic              ready_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  fresh_cnt_i,
  input  logic [CNT_W-1:0]  rpt_cnt_i,
  input  geom_t             geom_i,
  output logic              run_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              commit_o,
  output geom_t             wr_geom_o
);
  localparam logic [DIM_W-1:0] CAP_W = DIM_W'(MAX_W);
  localparam logic [DIM_W-1:0] CAP_H = DIM_W'(MAX_H);

  logic irq_clr;
  logic unused_wdata;

  assign commit_o  = we_i && (addr_i == A_GEOM);
  assign irq_clr   = we_i && (addr_i == A_IRQ) && wdata_i[0];
  assign wr_geom_o = '{w: wdata_i[W_LSB +: DIM_W], h: wdata_i[DIM_W-1:0]};
  assign unused_wdata = ^wdata_i[31:W_LSB+DIM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      irq_o  <= 1'b0;
      base_o <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) run_o  <= wdata_i[0];
      if (we_i && addr_i == A_BASE) base_o <= wdata_i[ADDR_W-1:0];
      if (frame_end_i)  irq_o <= 1'b1;
      else if (irq_clr) irq_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[0] = run_o;
      A_STAT:  rdata_o[0] = busy_i;
      A_IRQ:   rdata_o[0] = irq_o;
      A_FRESH: rdata_o = 32'(fresh_cnt_i);
      A_RPT:   rdata_o = 32'(rpt_cnt_i);
      A_GEOM:  rdata_o[W_LSB+DIM_W-1:0] = {geom_i.w, geom_i.h};
      A_BASE:  rdata_o = 32'(base_o);
      A_CAPS:  rdata_o[RDY_BIT:0] = {ready_i, CAP_W, CAP_H};
      default: rdata_o = '0;
    endcase
  end

  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> irq_o);
  // R6
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o);
endmodule

// File: rtl/frm_rd_desc_seq.sv
`timescale 1ns/1ps
module frm_rd_desc_seq
  import frm_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              commit_i,
  input  geom_t             commit_geom_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic              desc_ready_i,
  input  logic              frame_done_i,
  output logic              desc_valid_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output geom_t             desc_geom_o,
  output logic              desc_repeat_o,
  output geom_t             pend_geom_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic              fresh_inc_o,
  output logic              rpt_inc_o,
  output logic              frame_end_o
);
  logic              pending_q, in_flight_q, have_prev_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              launch, accept;

  assign launch      = run_i && !desc_valid_o && !in_flight_q && (pending_q || have_prev_q);
  assign accept      = desc_valid_o && desc_ready_i;
  assign frame_end_o = frame_done_i && in_flight_q;
  assign fresh_inc_o = accept && !desc_repeat_o;
  assign rpt_inc_o   = accept && desc_repeat_o;
  assign busy_o      = desc_valid_o || in_flight_q;
  // a fresh descriptor still on the port keeps software out
  assign ready_o     = !pending_q && !(desc_valid_o && !desc_repeat_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q     <= 1'b0;
      pend_addr_q   <= '0;
      pend_geom_o   <= '0;
      desc_valid_o  <= 1'b0;
      desc_addr_o   <= '0;
      desc_geom_o   <= '0;
      desc_repeat_o <= 1'b0;
      in_flight_q   <= 1'b0;
      have_prev_q   <= 1'b0;
    end else begin
      if (commit_i) begin
        pending_q   <= 1'b1;
        pend_addr_q <= commit_addr_i;
        pend_geom_o <= commit_geom_i;
      end else if (launch && pending_q) begin
        pending_q <= 1'b0;
      end
      if (launch) begin
        desc_valid_o  <= 1'b1;
        desc_repeat_o <= !pending_q;
        if (pending_q) begin
          desc_addr_o <= pend_addr_q;
          desc_geom_o <= pend_geom_o;
        end
      end else if (accept) begin
        desc_valid_o <= 1'b0;
        in_flight_q  <= 1'b1;
        if (!desc_repeat_o) have_prev_q <= 1'b1;
      end else if (frame_end_o) begin
        in_flight_q <= 1'b0;
      end
    end
  end

  // R4
  desc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=>
      (desc_valid_o && $stable(desc_addr_o) && $stable(desc_geom_o) && $stable(desc_repeat_o)));
  // R9
  launch_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desc_valid_o) |-> $past(run_i));
  // R3
  commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !ready_o);
  // R11
  stray_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/frame_rd_ctrl.sv
`timescale 1ns/1ps
module frame_rd_ctrl
  import frm_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MAX_W  = 1920,
  parameter int unsigned MAX_H  = 1080,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [12:0]       desc_width_o,
  output logic [12:0]       desc_height_o,
  output logic              desc_repeat_o,
  input  logic              frame_done_i
);
  localparam int unsigned N_CNT = 2;

  logic              run, commit, ready, busy, frame_end;
  logic [ADDR_W-1:0] base;
  geom_t             wr_geom, clp_geom, pend_geom, out_geom;
  logic [N_CNT-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_val [N_CNT];

  frm_rd_regs #(
    .ADDR_W(ADDR_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .CNT_W(CNT_W)
  ) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .frame_end_i(frame_end), .ready_i(ready), .busy_i(busy),
    .fresh_cnt_i(cnt_val[0]), .rpt_cnt_i(cnt_val[1]), .geom_i(pend_geom),
    .run_o(run), .irq_o, .base_o(base), .commit_o(commit), .wr_geom_o(wr_geom)
  );

  frm_rd_clamp #(.MAX_W(MAX_W), .MAX_H(MAX_H)) clamp_i (
    .raw_i(wr_geom), .clp_o(clp_geom)
  );

  frm_rd_desc_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk_i, .rst_ni,
    .run_i(run), .commit_i(commit), .commit_geom_i(clp_geom), .commit_addr_i(base),
    .desc_ready_i, .frame_done_i,
    .desc_valid_o, .desc_addr_o, .desc_geom_o(out_geom), .desc_repeat_o,
    .pend_geom_o(pend_geom), .ready_o(ready), .busy_o(busy),
    .fresh_inc_o(cnt_inc[0]), .rpt_inc_o(cnt_inc[1]), .frame_end_o(frame_end)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : gen_cnt
    frm_rd_cnt #(.W(CNT_W)) cnt_i (
      .clk_i, .rst_ni, .inc_i(cnt_inc[g]), .cnt_o(cnt_val[g])
    );
  end

  assign desc_width_o  = out_geom.w;
  assign desc_height_o = out_geom.h;

  // R5
  clamp_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (desc_width_o <= 13'(MAX_W) && desc_height_o <= 13'(MAX_H)));
  // R10
  busy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> reg_addr_i != 4'd1 || reg_rdata_o[0]);
endmodule

// File: tb/frame_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module frame_rd_ctrl_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned MAX_W  = 640;
  localparam int unsigned MAX_H  = 480;
  localparam int unsigned CNT_W  = 8;
  localparam logic [31:0] CAPS_RDY  = 32'h0450_01E0;
  localparam logic [31:0] CAPS_BUSY = 32'h0050_01E0;
  localparam logic [31:0] G_320     = 32'h0028_00F0;
  localparam logic [31:0] G_BIG     = 32'h007D_0384;
  localparam logic [31:0] G_MAX     = 32'h0050_01E0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [3:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq, dv, dr = 1'b0, drep, done = 1'b0;
  logic [ADDR_W-1:0] daddr;
  logic [12:0]       dw, dh;
  int                n_vec = 0;
  int                n_err = 0;

  always #2.5 clk = ~clk;

  frame_rd_ctrl #(.ADDR_W(ADDR_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .desc_valid_o(dv), .desc_ready_i(dr),
    .desc_addr_o(daddr), .desc_width_o(dw), .desc_height_o(dh),
    .desc_repeat_o(drep), .frame_done_i(done)
  );

  // {we, word, data}: write data when we=1, expected read-back when we=0
  localparam int N_VEC = 16;
  localparam logic [36:0] VECS [N_VEC] = '{
    {1'b0, 4'd0, 32'h0},          // R1 run
    {1'b0, 4'd2, 32'h0},          // R1 irq
    {1'b0, 4'd3, 32'h0},          // R1 fresh count
    {1'b0, 4'd4, 32'h0},          // R1 repeat count
    {1'b0, 4'd1, 32'h0},          // R1 busy
    {1'b0, 4'd7, CAPS_RDY},       // R2 caps
    {1'b1, 4'd6, 32'h1234_5678},
    {1'b0, 4'd6, 32'h1234_5678},  // R12 base read-back
    {1'b1, 4'd5, G_BIG},
    {1'b0, 4'd5, G_MAX},          // R5 clamped
    {1'b1, 4'd5, G_320},
    {1'b0, 4'd5, G_320},          // R5 in range kept
    {1'b0, 4'd7, CAPS_BUSY},      // R3 ready dropped
    {1'b0, 4'd1, 32'h0},          // R9 no launch while stopped
    {1'b1, 4'd2, 32'h1},
    {1'b0, 4'd2, 32'h0}           // R11 irq untouched
  };

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse_ready();
    dr = 1'b1; cyc(1); dr = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; cyc(1); done = 1'b0;
  endtask

  task automatic chk_desc(input string req, input logic [31:0] a, input logic [12:0] w,
                          input logic [12:0] h, input logic rep);
    chk(req, {31'b0, dv}, 32'h1);
    chk(req, daddr, a);
    chk(req, {19'b0, dw}, {19'b0, w});
    chk(req, {19'b0, dh}, {19'b0, h});
    chk(req, {31'b0, drep}, {31'b0, rep});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 valid", {31'b0, dv}, 32'h0);
    chk("R1 irq_o", {31'b0, irq}, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      if (VECS[i][36]) wr(VECS[i][35:32], VECS[i][31:0]);
      else rd(VECS[i][35:32], VECS[i][31:0], $sformatf("table %0d", i));
    end

    // fresh issue
    wr(4'd0, 32'h1);
    chk("R4 not before launch edge", {31'b0, dv}, 32'h0);
    cyc(1);
    chk_desc("R4 fresh", 32'h1234_5678, 13'd320, 13'd240, 1'b0);
    rd(4'd1, 32'h1, "R10 busy presented");
    cyc(3);
    chk_desc("R4 held", 32'h1234_5678, 13'd320, 13'd240, 1'b0);
    wr(4'd6, 32'hDEAD_0000);
    chk("R12 committed addr kept", daddr, 32'h1234_5678);
    pulse_ready();
    chk("R4 dropped after accept", {31'b0, dv}, 32'h0);
    rd(4'd3, 32'h1, "R8 fresh count");
    rd(4'd4, 32'h0, "R7 no repeat yet");
    rd(4'd7, CAPS_RDY, "R3 ready back");
    rd(4'd1, 32'h1, "R10 busy in flight");

    // end of frame, repeat
    pulse_done();
    chk("R6 irq_o set", {31'b0, irq}, 32'h1);
    rd(4'd2, 32'h1, "R6 irq word");
    cyc(1);
    chk_desc("R7 repeat", 32'h1234_5678, 13'd320, 13'd240, 1'b1);
    wr(4'd2, 32'h0);
    chk("R6 write 0 keeps", {31'b0, irq}, 32'h1);
    wr(4'd2, 32'h1);
    chk("R6 write 1 clears", {31'b0, irq}, 32'h0);
    pulse_ready();
    rd(4'd4, 32'h1, "R7 repeat count");
    rd(4'd3, 32'h1, "R8 fresh unchanged");

    // stray done
    pulse_done();
    cyc(1);
    wr(4'd2, 32'h1);
    pulse_done();
    chk("R11 irq stays clear", {31'b0, irq}, 32'h0);
    rd(4'd4, 32'h1, "R11 repeat count");
    chk("R11 valid held", {31'b0, dv}, 32'h1);

    // stop
    wr(4'd0, 32'h0);
    cyc(2);
    chk("R9 presented stays valid", {31'b0, dv}, 32'h1);
    pulse_ready();
    rd(4'd4, 32'h2, "R9 accepted while stopped");
    pulse_done();
    chk("R9 in-flight completes", {31'b0, irq}, 32'h1);
    cyc(3);
    chk("R9 no relaunch", {31'b0, dv}, 32'h0);
    rd(4'd1, 32'h0, "R10 idle");

    // clamped commit with the new base
    wr(4'd5, G_BIG);
    rd(4'd7, CAPS_BUSY, "R3 ready low after commit");
    cyc(2);
    chk("R9 waiting while stopped", {31'b0, dv}, 32'h0);
    wr(4'd0, 32'h1);
    cyc(1);
    chk_desc("R5 clamped on port", 32'hDEAD_0000, 13'd640, 13'd480, 1'b0);
    pulse_ready();
    rd(4'd3, 32'h2, "R8 second fresh");
    rd(4'd6, 32'hDEAD_0000, "R12 base");

    // reset mid-flight
    rst_n = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    rd(4'd3, 32'h0, "R1 count after reset");
    rd(4'd0, 32'h0, "R1 run after reset");
    rd(4'd7, CAPS_RDY, "R1 ready after reset");
    chk("R1 valid after reset", {31'b0, dv}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule